// File: doc/BRIEF.md
# Quick DMA Channel Trigger Logic

This block sits beside a parameter RAM whose entries are sets of eight 32-bit words. It watches every write that lands in that RAM, whether it comes from the programmer's bus or from the internal link-copy engine. It turns the writes that hit a channel's configured trigger word into events for that channel. Each channel has a mapping that names one parameter set and one word within it. A write to that word, while the channel is enabled, raises the channel's event flag. If the flag is already up, the repeat is recorded as a miss.

Pending events pass through a fixed-priority arbiter into a short in-order queue. The entry at the head of the queue is checked against the count fields of its parameter set. The RAM supplies those counts for the set number the block presents. A set with real work becomes a transfer request carrying the channel and set numbers, under a valid/ready handshake. An all-zero (null) set is dropped silently. In both cases the channel's event flag then falls, so the channel can fire again. Software can clear either flag array with write-one-to-clear strobes.

Top module: `qdma_trig`

## Requirements
- R1: A programmer write (`pw_valid`) whose set and word equal channel c's mapping (`map_set`, `map_word`) sets `evt_flags[c]` one clock later, provided `ch_en[c]` is 1.
- R2: Word indices 0 (options), 1 (source) and 3 (destination) trigger only on a full write with `pw_be` equal to 4'b1111. Any other word index triggers when at least one byte enable is 1. A write with all byte enables at 0 never triggers.
- R3: A link update (`lk_valid`) with `lk_static` at 0 copies a whole set, so it triggers every enabled channel whose `map_set` equals `lk_set`, whatever that channel's trigger word. With `lk_static` at 1, no copy takes place and nothing is triggered.
- R4: A channel with `ch_en[c]` at 0 never has its event flag set by a write or by a link update.
- R5: A trigger for channel c that arrives while `evt_flags[c]` is 1 sets `miss_flags[c]` one clock later. The miss flag holds until it is cleared.
- R6: `evt_clr[c]` and `miss_clr[c]` clear the matching flag on the next clock. When a set and a clear of the same flag meet in one cycle, the flag ends up set.
- R7: When several channels have pending events, the lowest-numbered channel enters the queue first, at most one channel per clock. The queue holds 4 entries, and a pending event waits while the queue is full.
- R8: A non-null head entry raises `tr_valid`, with `tr_ch`/`tr_set` giving its channel and set. These outputs are held until `tr_ready` is 1. The handshake removes the entry and clears that channel's event flag on the same clock.
- R9: When the head entry's `hd_cnt` is all zero, `tr_valid` stays 0. The entry is discarded on the next clock and the channel's event flag is cleared.
- R10: After reset, all event and miss flags are 0, the queue is empty, and `tr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_set | input | NUM_CH*SET_W | Per-channel mapped parameter-set number, channel c in bits [c*SET_W +: SET_W] |
| map_word | input | NUM_CH*3 | Per-channel trigger-word index within the set |
| ch_en | input | NUM_CH | Per-channel trigger enable |
| pw_valid | input | 1 | Programmer write strobe into the parameter RAM |
| pw_set | input | SET_W | Set number of the programmer write |
| pw_word | input | 3 | Word index of the programmer write |
| pw_be | input | 4 | Byte enables of the programmer write |
| lk_valid | input | 1 | Link-copy strobe |
| lk_set | input | SET_W | Set number overwritten by the link copy |
| lk_static | input | 1 | Static bit of the options word; 1 suppresses the copy |
| evt_clr | input | NUM_CH | Write-one-to-clear strobes for event flags |
| miss_clr | input | NUM_CH | Write-one-to-clear strobes for miss flags |
| evt_flags | output | NUM_CH | Event register |
| miss_flags | output | NUM_CH | Miss register |
| hd_set | output | SET_W | Set number of the queue head, used for the count lookup |
| hd_cnt | input | 48 | Count fields of set `hd_set`, supplied by the RAM |
| tr_valid | output | 1 | Transfer request valid |
| tr_ready | input | 1 | Transfer request accepted |
| tr_ch | output | CH_W | Channel of the request |
| tr_set | output | SET_W | Parameter set of the request |

## Verification
The hardest condition to reach is a full queue with more channels still pending behind it. Only then do the arbiter's priority order and its wait on a full queue become visible at the ports. The bench maps all eight channels to one set and holds `tr_ready` low. It then issues a single link update on that set, which raises all eight events in the same clock. It then releases the requests one handshake at a time and expects channels 0 through 7 in strict order.

// File: rtl/qdma_trig_pkg.sv
package qdma_trig_pkg;

  localparam int WORD_W = 3;
  localparam int BE_W   = 4;
  localparam int CNT_W  = 48;

  // Word indices whose trigger demands a full-width write.
  function automatic logic word_needs_full(input logic [WORD_W-1:0] w);
    return (w == 3'd0) || (w == 3'd1) || (w == 3'd3);
  endfunction

  function automatic logic be_qualifies(input logic [WORD_W-1:0] w,
                                        input logic [BE_W-1:0]   be);
    return word_needs_full(w) ? (be == 4'hF) : (be != 4'h0);
  endfunction

  function automatic logic set_is_null(input logic [CNT_W-1:0] cnt);
    return cnt == '0;
  endfunction

endpackage

// File: rtl/qdma_trig_match.sv
module qdma_trig_match
  import qdma_trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SET_W  = 7
) (
  input  logic [NUM_CH*SET_W-1:0]  map_set,
  input  logic [NUM_CH*WORD_W-1:0] map_word,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic                     pw_valid,
  input  logic [SET_W-1:0]         pw_set,
  input  logic [WORD_W-1:0]        pw_word,
  input  logic [BE_W-1:0]          pw_be,
  input  logic                     lk_valid,
  input  logic [SET_W-1:0]         lk_set,
  input  logic                     lk_static,
  output logic [NUM_CH-1:0]        hit
);

  logic pw_ok;
  logic lk_ok;

  assign pw_ok = pw_valid && be_qualifies(pw_word, pw_be);
  assign lk_ok = lk_valid && !lk_static;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SET_W-1:0]  cs;
    logic [WORD_W-1:0] cw;
    logic              pw_hit;
    logic              lk_hit;
    assign cs     = map_set[c*SET_W +: SET_W];
    assign cw     = map_word[c*WORD_W +: WORD_W];
    assign pw_hit = pw_ok && (pw_set == cs) && (pw_word == cw);
    assign lk_hit = lk_ok && (lk_set == cs);
    assign hit[c] = ch_en[c] && (pw_hit || lk_hit);
  end

endmodule

// File: rtl/qdma_trig_pick.sv
module qdma_trig_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/qdma_trig_fifo.sv
module qdma_trig_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 10,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/qdma_trig.sv
module qdma_trig
  import qdma_trig_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int SET_W   = 7,
  parameter int Q_DEPTH = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int QC_W   = $clog2(Q_DEPTH + 1),
  localparam int ENT_W  = CH_W + SET_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*SET_W-1:0]  map_set,
  input  logic [NUM_CH*3-1:0]      map_word,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic                     pw_valid,
  input  logic [SET_W-1:0]         pw_set,
  input  logic [2:0]               pw_word,
  input  logic [3:0]               pw_be,
  input  logic                     lk_valid,
  input  logic [SET_W-1:0]         lk_set,
  input  logic                     lk_static,
  input  logic [NUM_CH-1:0]        evt_clr,
  input  logic [NUM_CH-1:0]        miss_clr,
  output logic [NUM_CH-1:0]        evt_flags,
  output logic [NUM_CH-1:0]        miss_flags,
  output logic [SET_W-1:0]         hd_set,
  input  logic [47:0]              hd_cnt,
  output logic                     tr_valid,
  input  logic                     tr_ready,
  output logic [CH_W-1:0]          tr_ch,
  output logic [SET_W-1:0]         tr_set
);

  logic [NUM_CH-1:0] evt_q, miss_q, inq_q;
  logic [NUM_CH-1:0] hit_vec;
  logic [NUM_CH-1:0] pend_vec;
  logic [NUM_CH-1:0] pick_gnt;
  logic [CH_W-1:0]   pick_idx;
  logic              pick_any;
  logic              q_push, q_pop, q_full, q_empty;
  logic [QC_W-1:0]   q_count;
  logic [ENT_W-1:0]  q_din, q_dout;
  logic [CH_W-1:0]   hd_ch;
  logic              hd_null;
  logic              null_drop;
  logic [NUM_CH-1:0] pop_vec;
  logic [NUM_CH-1:0] push_vec;

  qdma_trig_match #(.NUM_CH(NUM_CH), .SET_W(SET_W)) u_match (
    .map_set  (map_set),
    .map_word (map_word),
    .ch_en    (ch_en),
    .pw_valid (pw_valid),
    .pw_set   (pw_set),
    .pw_word  (pw_word),
    .pw_be    (pw_be),
    .lk_valid (lk_valid),
    .lk_set   (lk_set),
    .lk_static(lk_static),
    .hit      (hit_vec)
  );

  // Pending = latched but not yet holding a queue slot.
  assign pend_vec = evt_q & ~inq_q;

  qdma_trig_pick #(.N(NUM_CH)) u_pick (
    .req(pend_vec),
    .gnt(pick_gnt),
    .idx(pick_idx),
    .any(pick_any)
  );

  assign q_push = pick_any && !q_full;
  assign q_din  = {pick_idx, map_set[pick_idx*SET_W +: SET_W]};

  qdma_trig_fifo #(.DEPTH(Q_DEPTH), .DW(ENT_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (q_push),
    .din  (q_din),
    .pop  (q_pop),
    .dout (q_dout),
    .count(q_count),
    .full (q_full),
    .empty(q_empty)
  );

  assign hd_ch     = q_dout[ENT_W-1 -: CH_W];
  assign hd_set    = q_dout[SET_W-1:0];
  assign hd_null   = set_is_null(hd_cnt);
  assign tr_valid  = !q_empty && !hd_null;
  assign tr_ch     = hd_ch;
  assign tr_set    = hd_set;
  assign null_drop = !q_empty && hd_null;
  assign q_pop     = null_drop || (tr_valid && tr_ready);

  assign pop_vec  = q_pop  ? (NUM_CH'(1) << hd_ch) : '0;
  assign push_vec = q_push ? pick_gnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      miss_q <= '0;
      inq_q  <= '0;
    end else begin
      evt_q  <= (evt_q & ~evt_clr & ~pop_vec) | hit_vec;
      miss_q <= (miss_q & ~miss_clr) | (hit_vec & evt_q);
      inq_q  <= (inq_q & ~pop_vec) | push_vec;
    end
  end

  assign evt_flags  = evt_q;
  assign miss_flags = miss_q;

endmodule

// File: rtl/qdma_trig_chk.sv
module qdma_trig_chk #(
  parameter int NUM_CH  = 8,
  parameter int SET_W   = 7,
  parameter int Q_DEPTH = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int QC_W   = $clog2(Q_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] hit_vec,
  input logic [NUM_CH-1:0] evt_flags,
  input logic [NUM_CH-1:0] miss_flags,
  input logic              tr_valid,
  input logic              tr_ready,
  input logic [CH_W-1:0]   tr_ch,
  input logic [SET_W-1:0]  tr_set,
  input logic [47:0]       hd_cnt,
  input logic [QC_W-1:0]   q_count
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R1
    a_r1_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[c] |=> evt_flags[c]);
    // R5
    a_r5_repeat_misses: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[c] && evt_flags[c] |=> miss_flags[c]);
    // R4
    a_r4_no_spurious_evt: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_flags[c] && !hit_vec[c] |=> !evt_flags[c]);
  end

  // R8
  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && !tr_ready |=> tr_valid && $stable(tr_ch) && $stable(tr_set));

  // R9
  a_r9_null_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |-> hd_cnt != '0);

  // R7
  a_r7_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QC_W'(Q_DEPTH));

endmodule

bind qdma_trig qdma_trig_chk #(.NUM_CH(NUM_CH), .SET_W(SET_W), .Q_DEPTH(Q_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit_vec   (hit_vec),
  .evt_flags (evt_flags),
  .miss_flags(miss_flags),
  .tr_valid  (tr_valid),
  .tr_ready  (tr_ready),
  .tr_ch     (tr_ch),
  .tr_set    (tr_set),
  .hd_cnt    (hd_cnt),
  .q_count   (q_count)
);

// File: tb/qdma_trig_bench.sv
`timescale 1ns/1ps
module qdma_trig_bench;

  localparam int NCH = 8;
  localparam int SW  = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH*SW-1:0] map_set;
  logic [NCH*3-1:0]  map_word;
  logic [NCH-1:0]  ch_en = '1;
  logic            pw_valid = 0;
  logic [SW-1:0]   pw_set = '0;
  logic [2:0]      pw_word = '0;
  logic [3:0]      pw_be = '0;
  logic            lk_valid = 0;
  logic [SW-1:0]   lk_set = '0;
  logic            lk_static = 0;
  logic [NCH-1:0]  evt_clr = '0;
  logic [NCH-1:0]  miss_clr = '0;
  logic [NCH-1:0]  evt_flags, miss_flags;
  logic [SW-1:0]   hd_set;
  logic [47:0]     hd_cnt;
  logic            tr_valid;
  logic            tr_ready = 0;
  logic [2:0]      tr_ch;
  logic [SW-1:0]   tr_set;

  logic [SW-1:0]   b_set [NCH];
  logic [2:0]      b_word [NCH];
  logic [127:0]    null_mask = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      map_set[i*SW +: SW] = b_set[i];
      map_word[i*3 +: 3]  = b_word[i];
    end
  end

  assign hd_cnt = null_mask[hd_set] ? 48'd0 : 48'h0001_0001_0004;

  qdma_trig u_qdma_trig (
    .clk(clk), .rst_n(rst_n), .map_set(map_set), .map_word(map_word), .ch_en(ch_en),
    .pw_valid(pw_valid), .pw_set(pw_set), .pw_word(pw_word), .pw_be(pw_be),
    .lk_valid(lk_valid), .lk_set(lk_set), .lk_static(lk_static),
    .evt_clr(evt_clr), .miss_clr(miss_clr), .evt_flags(evt_flags), .miss_flags(miss_flags),
    .hd_set(hd_set), .hd_cnt(hd_cnt), .tr_valid(tr_valid), .tr_ready(tr_ready),
    .tr_ch(tr_ch), .tr_set(tr_set)
  );

  function automatic logic exp_trig(input int w, input logic [3:0] be);
    if (w == 0 || w == 1 || w == 3) return be == 4'b1111;
    return be != 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pw(input int s, input int w, input logic [3:0] be);
    pw_valid = 1; pw_set = SW'(s); pw_word = 3'(w); pw_be = be;
    tick();
    pw_valid = 0; pw_be = '0;
  endtask

  task automatic lk(input int s, input logic st);
    lk_valid = 1; lk_set = SW'(s); lk_static = st;
    tick();
    lk_valid = 0; lk_static = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      b_set[i]  = SW'(i * 3 + 1);
      b_word[i] = 3'(i);
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 evt after reset", 32'(evt_flags), 0);
    check("R10 miss after reset", 32'(miss_flags), 0);
    check("R10 tr_valid after reset", 32'(tr_valid), 0);
    rst_n = 1;
    tick();

    // R1/R2/R8: every channel, every byte-enable pattern, requests consumed
    tr_ready = 1;
    for (int c = 0; c < NCH; c++) begin
      for (int be = 0; be < 16; be++) begin
        pw(c * 3 + 1, c, 4'(be));
        check($sformatf("R2 R1 ch%0d be%0h evt", c, be), 32'(evt_flags),
              exp_trig(c, 4'(be)) ? (32'd1 << c) : 32'd0);
        repeat (4) tick();
        check($sformatf("R8 ch%0d evt cleared after request", c), 32'(evt_flags), 0);
      end
      pw(c * 3 + 1, (c + 1) % 8, 4'hF);
      check($sformatf("R1 ch%0d wrong word no event", c), 32'(evt_flags), 0);
      pw(c * 3 + 2, c, 4'hF);
      check($sformatf("R1 ch%0d wrong set no event", c), 32'(evt_flags), 0);
    end
    check("R5 no miss during sweep", 32'(miss_flags), 0);

    // R3 link update
    lk(4 * 3 + 1, 1'b1);
    check("R3 static link ignored", 32'(evt_flags), 0);
    lk(4 * 3 + 1, 1'b0);
    check("R3 link triggers ch4", 32'(evt_flags), 32'h10);
    repeat (4) tick();
    check("R3 link event consumed", 32'(evt_flags), 0);

    // R4 disabled channel
    ch_en[6] = 0;
    pw(6 * 3 + 1, 6, 4'hF);
    check("R4 disabled pw", 32'(evt_flags), 0);
    lk(6 * 3 + 1, 1'b0);
    check("R4 disabled link", 32'(evt_flags), 0);
    ch_en[6] = 1;

    // R5/R6 miss and clears
    tr_ready = 0;
    pw(2 * 3 + 1, 2, 4'h1);
    check("R5 first trigger no miss", 32'(miss_flags), 0);
    pw(2 * 3 + 1, 2, 4'h2);
    check("R5 repeat sets miss", 32'(miss_flags), 32'h4);
    repeat (2) tick();
    check("R5 miss holds", 32'(miss_flags), 32'h4);
    miss_clr = 8'h04; tick(); miss_clr = '0;
    check("R6 miss cleared", 32'(miss_flags), 0);
    miss_clr = 8'h04;
    pw(2 * 3 + 1, 2, 4'h8);
    miss_clr = '0;
    check("R6 miss set wins over clear", 32'(miss_flags), 32'h4);
    evt_clr = 8'h04; tick(); evt_clr = '0;
    check("R6 evt cleared", 32'(evt_flags), 0);
    evt_clr = 8'h04;
    pw(2 * 3 + 1, 2, 4'hF);
    evt_clr = '0;
    check("R6 evt set wins over clear", 32'(evt_flags), 32'h4);
    miss_clr = '1; tick(); miss_clr = '0;
    check("R8 head waits on ready", 32'(tr_valid), 1);
    check("R8 head channel", 32'(tr_ch), 2);
    check("R8 head set", 32'(tr_set), 7);
    tr_ready = 1;
    repeat (3) tick();
    check("R8 drained evt", 32'(evt_flags), 0);
    check("R8 drained valid", 32'(tr_valid), 0);

    // R9 null set
    null_mask[5 * 3 + 1] = 1'b1;
    pw(5 * 3 + 1, 5, 4'hF);
    check("R9 null event latched", 32'(evt_flags), 32'h20);
    for (int k = 0; k < 4; k++) begin
      check("R9 no request for null set", 32'(tr_valid), 0);
      tick();
    end
    check("R9 null entry dropped evt cleared", 32'(evt_flags), 0);
    null_mask = '0;

    // R7 priority and full queue: all channels on one set
    tr_ready = 0;
    for (int i = 0; i < NCH; i++) b_set[i] = SW'(50);
    lk(50, 1'b0);
    check("R3 R7 link hits all channels", 32'(evt_flags), 32'hFF);
    repeat (6) tick();
    check("R7 pending wait while full", 32'(evt_flags), 32'hFF);
    check("R8 set number on request", 32'(tr_set), 50);
    for (int k = 0; k < NCH; k++) begin
      check($sformatf("R7 order position %0d", k), 32'(tr_ch), 32'(k));
      check($sformatf("R7 valid position %0d", k), 32'(tr_valid), 1);
      tr_ready = 1; tick(); tr_ready = 0;
      check($sformatf("R8 evt of ch%0d cleared on handshake", k),
            32'(evt_flags[k]), 0);
    end
    check("R7 queue empty after drain", 32'(tr_valid), 0);
    check("R5 no miss in priority test", 32'(miss_flags), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule